// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation converter. It runs directly on the divided converter clock and counts the cycles of each conversion. During a conversion it raises a sample strobe for the analog hold stage. It then walks a trial code from the most significant bit down to the least, one bit per cycle. A comparator input tells it whether each trial bit stays. At the end it loads the 10-bit answer into two 8-bit result registers and raises a completion flag.

Conversions run in two modes. In single-shot mode, a start request runs one conversion. In free-running mode, conversions follow each other with no gap. The first conversion after enable rises uses a longer sequence.

Channel and reference selection go through two registers. A CPU-writable holding register is copied into the live multiplexer control. The copy is continuous while the sequencer is idle. It is blocked from the first cycle of a conversion until its final cycle, where it opens again so that a late write lands in time for the next conversion.

Top module: `sar_seq_top`

## Requirements
- R1: After reset `busy`, `done_flag`, `start_bit`, `res_hi`, `res_lo` and `mux_sel` are all zero.
- R2: With `en` high and the sequencer idle, a clock edge that samples `start_wr` high or `start_bit` set begins a conversion: `busy` is high after that edge, which ends nothing and counts as the start of cycle 1.
- R3: A normal conversion raises `sample_stb` in cycle 2 and `decide_stb` in cycles 3 to 12, and it sets `done_flag` at the edge that ends cycle 13.
- R4: The first conversion after `en` goes from 0 to 1 is extended: `sample_stb` comes in cycle 14, there are 10 decision cycles, and `done_flag` is set at the edge that ends cycle 25. Later conversions are normal.
- R5: `dac_code` becomes 10'b1000000000 after the sample cycle. In each decision cycle, `cmp_in` = 1 keeps the current trial bit and 0 clears it, and the next lower bit is then tried. On completion `res_hi[1:0]` holds result bits 9:8, `res_hi[7:2]` is zero and `res_lo` holds bits 7:0.
- R6: `done_flag` stays set until a cycle with `flag_clr` high. If completion and `flag_clr` fall in the same cycle, the flag is set.
- R7: In single-shot mode (`free_run` = 0), completion clears `start_bit` and drops `busy`.
- R8: With `free_run` and `en` high, the edge that completes a conversion also starts the next one, which is a normal conversion. `busy` stays high throughout.
- R9: While idle, a selection written with `sel_wr` appears on `mux_sel` after the edge that samples the write.
- R10: During cycles 1 to N-1 of a conversion (N = 13 or 25), `mux_sel` does not change, whatever is written.
- R11: In cycle N, `mux_sel` takes the held selection, including a write made in that same cycle, so the value applies to the following conversion.
- R12: Lowering `en` aborts any conversion and clears `start_bit`. No flag is set for the aborted conversion, and `start_wr` is ignored while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable |
| free_run | input | 1 | Free-running mode select |
| start_wr | input | 1 | CPU writes 1 to the start bit (one-cycle pulse) |
| flag_clr | input | 1 | CPU writes 1 to the completion flag (one-cycle pulse) |
| sel_wr | input | 1 | CPU writes the selection holding register |
| sel_din | input | 6 | Channel and reference selection value to write |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial code |
| start_bit | output | 1 | CPU-visible start bit |
| done_flag | output | 1 | Completion flag |
| busy | output | 1 | Conversion in progress |
| ext_active | output | 1 | Current conversion uses the extended sequence |
| sample_stb | output | 1 | Sample-and-hold strobe for the analog stage |
| decide_stb | output | 1 | Bit-decision strobe; `cmp_in` is used in this cycle |
| dac_code | output | 10 | Trial code for the comparison DAC |
| mux_sel | output | 6 | Live channel and reference selection |
| res_hi | output | 8 | High result register, right-adjusted |
| res_lo | output | 8 | Low result register |

## Verification
Two pairs of events can fall in the same cycle. The completion of a conversion can coincide with a CPU clear of the flag. The release of the selection lock can coincide with a CPU write of a new selection. Both are provoked in a free-running chain by counting cycles from a known completion and pulsing `flag_clr` and `sel_wr` in cycle 13. The flag is judged to be still set after that edge. The live selection is judged to already show the value written in the same cycle, while a write in cycle 5 must not show before the completion edge.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TRACK,
    PH_SAMPLE,
    PH_DECIDE,
    PH_FINISH
  } phase_e;

  // Decode the position inside a conversion from the cycle count.
  function automatic phase_e classify(input logic busy, input logic [7:0] cyc,
                                      input logic [7:0] sh, input logic [7:0] len);
    if (!busy)          return PH_IDLE;
    else if (cyc == len) return PH_FINISH;
    else if (cyc == sh)  return PH_SAMPLE;
    else if (cyc > sh)   return PH_DECIDE;
    else                 return PH_TRACK;
  endfunction

endpackage

// File: rtl/sar_timing.sv
module sar_timing #(
  parameter int RES_W   = 10,
  parameter int NORM_SH = 2,
  parameter int EXT_SH  = 14,
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             go_req,
  input  logic             free_run,
  input  logic             ext_req,
  output logic             busy,
  output logic             ext,
  output logic             conv_start,
  output logic             last_cyc,
  output logic             sample_stb,
  output logic             decide_stb,
  output logic [IDX_W-1:0] bit_idx
);
  import sar_pkg::*;

  logic [CNT_W-1:0] cyc;
  logic [CNT_W-1:0] sh_c, len_c;
  phase_e           phase;

  assign sh_c  = ext ? CNT_W'(EXT_SH) : CNT_W'(NORM_SH);
  assign len_c = sh_c + CNT_W'(RES_W + 1);
  assign phase = classify(busy, 8'(cyc), 8'(sh_c), 8'(len_c));

  assign conv_start = en && !busy && go_req;
  assign last_cyc   = (phase == PH_FINISH);
  assign sample_stb = (phase == PH_SAMPLE);
  assign decide_stb = (phase == PH_DECIDE);
  assign bit_idx    = IDX_W'(sh_c + CNT_W'(RES_W) - cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cyc  <= '0;
      ext  <= 1'b0;
    end else if (!en) begin
      busy <= 1'b0;
      cyc  <= '0;
      ext  <= 1'b0;
    end else if (!busy) begin
      if (go_req) begin
        busy <= 1'b1;
        cyc  <= CNT_W'(1);
        ext  <= ext_req;
      end
    end else if (last_cyc) begin
      if (free_run) begin
        cyc <= CNT_W'(1);
        ext <= 1'b0;
      end else begin
        busy <= 1'b0;
        cyc  <= '0;
        ext  <= 1'b0;
      end
    end else begin
      cyc <= cyc + CNT_W'(1);
    end
  end

  a_r8_no_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && en && free_run) |=> (busy && cyc == CNT_W'(1) && !ext));

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && decide_stb) && !(sample_stb && last_cyc));

  a_r12_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (busy && cyc == CNT_W'(1)));

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic             decide_stb,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp_in,
  input  logic             conv_done,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);

  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  // One successive-approximation step: settle bit k, try bit k-1.
  function automatic logic [RES_W-1:0] sar_step(input logic [RES_W-1:0] a,
                                                input logic [IDX_W-1:0] k,
                                                input logic keep);
    logic [RES_W-1:0] n;
    n = a;
    for (int i = 0; i < RES_W; i++) begin
      if (i == int'(k) && !keep) n[i] = 1'b0;
      if (i + 1 == int'(k))      n[i] = 1'b1;
    end
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial  <= '0;
      result <= '0;
    end else begin
      if (sample_stb)      trial <= MSB_ONLY;
      else if (decide_stb) trial <= sar_step(trial, bit_idx, cmp_in);
      if (conv_done)       result <= trial;
    end
  end

  a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> (trial == MSB_ONLY));

  a_r5_result_load: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (result == $past(trial)));

endmodule

// File: rtl/sar_sel_guard.sv
module sar_sel_guard #(
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_din,
  input  logic             busy,
  input  logic             last_cyc,
  output logic [SEL_W-1:0] mux_sel
);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_next;
  logic             unlocked;

  assign sel_next = sel_wr ? sel_din : sel_q;
  assign unlocked = !busy || last_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      mux_sel <= '0;
    end else begin
      sel_q <= sel_next;
      if (unlocked) mux_sel <= sel_next;
    end
  end

  a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_cyc) |=> $stable(mux_sel));

  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && sel_wr) |=> (mux_sel == $past(sel_din)));

  a_r9_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sel_wr) |=> (mux_sel == $past(sel_din)));

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int RES_W   = 10,
  parameter int REG_W   = 8,
  parameter int SEL_W   = 6,
  parameter int NORM_SH = 2,
  parameter int EXT_SH  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             free_run,
  input  logic             start_wr,
  input  logic             flag_clr,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_din,
  input  logic             cmp_in,
  output logic             start_bit,
  output logic             done_flag,
  output logic             busy,
  output logic             ext_active,
  output logic             sample_stb,
  output logic             decide_stb,
  output logic [RES_W-1:0] dac_code,
  output logic [SEL_W-1:0] mux_sel,
  output logic [REG_W-1:0] res_hi,
  output logic [REG_W-1:0] res_lo
);

  localparam int CNT_W = $clog2(EXT_SH + RES_W + 2);
  localparam int IDX_W = $clog2(RES_W);

  logic             en_q, en_rise, first_pend, ext_req;
  logic             conv_start, last_cyc, conv_done;
  logic [IDX_W-1:0] bit_idx;
  logic [RES_W-1:0] result;

  assign en_rise   = en && !en_q;
  assign ext_req   = first_pend || en_rise;
  assign conv_done = last_cyc && en;

  sar_timing #(
    .RES_W(RES_W), .NORM_SH(NORM_SH), .EXT_SH(EXT_SH),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .en(en),
    .go_req(start_wr || start_bit), .free_run(free_run), .ext_req(ext_req),
    .busy(busy), .ext(ext_active), .conv_start(conv_start), .last_cyc(last_cyc),
    .sample_stb(sample_stb), .decide_stb(decide_stb), .bit_idx(bit_idx)
  );

  sar_approx #(.RES_W(RES_W), .IDX_W(IDX_W)) u_approx (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .decide_stb(decide_stb),
    .bit_idx(bit_idx), .cmp_in(cmp_in), .conv_done(conv_done),
    .trial(dac_code), .result(result)
  );

  sar_sel_guard #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_din(sel_din),
    .busy(busy), .last_cyc(last_cyc), .mux_sel(mux_sel)
  );

  assign res_hi = REG_W'(result >> REG_W);
  assign res_lo = result[REG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      first_pend <= 1'b0;
      start_bit  <= 1'b0;
      done_flag  <= 1'b0;
    end else begin
      en_q <= en;
      if (conv_start)   first_pend <= 1'b0;
      else if (en_rise) first_pend <= 1'b1;
      if (!en)                            start_bit <= 1'b0;
      else if (start_wr)                  start_bit <= 1'b1;
      else if (conv_done && !free_run)    start_bit <= 1'b0;
      if (conv_done)     done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
    end
  end

  a_r6_set_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_flag);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !conv_done) |=> !done_flag);

  a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !free_run && !start_wr) |=> !start_bit);

  a_r4_first_extended: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && ext_req) |=> ext_active);

endmodule

// File: tb/sim_sar_seq_top.sv
module sim_sar_seq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, free_run = 1'b0, start_wr = 1'b0, flag_clr = 1'b0;
  logic       sel_wr = 1'b0;
  logic [5:0] sel_din = '0;
  logic       cmp_in;
  logic       start_bit, done_flag, busy, ext_active, sample_stb, decide_stb;
  logic [9:0] dac_code;
  logic [5:0] mux_sel;
  logic [7:0] res_hi, res_lo;
  logic [9:0] vin = '0;

  int n_chk = 0;
  int n_bad = 0;

  sar_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .free_run(free_run), .start_wr(start_wr),
    .flag_clr(flag_clr), .sel_wr(sel_wr), .sel_din(sel_din), .cmp_in(cmp_in),
    .start_bit(start_bit), .done_flag(done_flag), .busy(busy), .ext_active(ext_active),
    .sample_stb(sample_stb), .decide_stb(decide_stb), .dac_code(dac_code),
    .mux_sel(mux_sel), .res_hi(res_hi), .res_lo(res_lo)
  );

  // Abstract analog front end: ideal comparator against the trial code.
  assign cmp_in = (vin >= dac_code);

  always #2 clk = ~clk;

  function automatic int exp_hold(input bit ext);
    return ext ? 14 : 2;
  endfunction

  function automatic int exp_len(input bit ext);
    return exp_hold(ext) + 10 + 1;
  endfunction

  function automatic logic [7:0] exp_hi(input logic [9:0] v);
    return {6'b000000, v[9:8]};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    chk(done_flag == 1'b0, "R6 clear", done_flag, 0);
  endtask

  task automatic run_conv(input bit ext, input logic [9:0] v);
    int samp, ndec, len;
    string tag;
    tag = ext ? "R4" : "R3";
    samp = 0; ndec = 0; len = 0;
    vin = v;
    start_wr = 1'b1;
    tick();
    start_wr = 1'b0;
    chk(busy == 1'b1, "R2 busy after start edge", busy, 1);
    for (int c = 1; c <= 60; c++) begin
      if (sample_stb) samp = c;
      if (decide_stb) ndec++;
      tick();
      if (done_flag) begin
        len = c;
        break;
      end
    end
    chk(len == exp_len(ext), {tag, " length"}, len, exp_len(ext));
    chk(samp == exp_hold(ext), {tag, " sample cycle"}, samp, exp_hold(ext));
    chk(ndec == 10, {tag, " decision count"}, ndec, 10);
    chk(res_hi == exp_hi(v), "R5 high result", res_hi, exp_hi(v));
    chk(res_lo == v[7:0], "R5 low result", res_lo, v[7:0]);
    chk(busy == 1'b0 && start_bit == 1'b0, "R7 single-shot end", {busy, start_bit}, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [5:0] old_sel, sel_a, sel_b;
    logic [9:0] v1, v2, v3;
    void'($urandom(32'd4242));
    #9;
    chk({busy, done_flag, start_bit} == 3'b000, "R1 control reset", {busy, done_flag, start_bit}, 0);
    chk(res_hi == 8'd0 && res_lo == 8'd0, "R1 result reset", {res_hi, res_lo}, 0);
    chk(mux_sel == 6'd0, "R1 mux reset", mux_sel, 0);
    rst_n = 1'b1;
    tick();
    en = 1'b1;
    tick();

    // R9: idle selection follows writes
    sel_din = 6'h2d; sel_wr = 1'b1;
    tick();
    sel_wr = 1'b0;
    chk(mux_sel == 6'h2d, "R9 idle follow", mux_sel, 6'h2d);

    // R4: first conversion after enable is extended
    run_conv(1'b1, 10'd613);
    repeat (3) tick();
    chk(done_flag == 1'b1, "R6 flag holds", done_flag, 1);
    clear_flag();

    // Directed extremes then random single-shot conversions (R3, R5)
    run_conv(1'b0, 10'd0);
    clear_flag();
    run_conv(1'b0, 10'd1023);
    clear_flag();
    for (int i = 0; i < 14; i++) begin
      logic [5:0] s;
      s = 6'($urandom);
      sel_din = s; sel_wr = 1'b1;
      tick();
      sel_wr = 1'b0;
      chk(mux_sel == s, "R9 idle follow random", mux_sel, s);
      run_conv(1'b0, 10'($urandom));
      clear_flag();
    end

    // Free-running chain with same-cycle collisions (R8, R6, R10, R11)
    v1 = 10'($urandom); v2 = 10'($urandom); v3 = 10'($urandom);
    free_run = 1'b1;
    vin = v1;
    start_wr = 1'b1;
    tick();
    start_wr = 1'b0;
    repeat (12) tick();
    chk(done_flag == 1'b0, "R8 not done before cycle 13 ends", done_flag, 0);
    tick();
    chk(done_flag == 1'b1 && busy == 1'b1, "R8 chained start", {done_flag, busy}, 3);
    chk({res_hi[1:0], res_lo} == v1, "R5 free-run result 1", {res_hi[1:0], res_lo}, v1);
    vin = v2;
    old_sel = mux_sel;
    sel_a = old_sel ^ 6'h15;
    repeat (4) tick();
    sel_din = sel_a; sel_wr = 1'b1;
    tick();
    sel_wr = 1'b0;
    chk(mux_sel == old_sel, "R10 locked after write", mux_sel, old_sel);
    repeat (6) tick();
    chk(mux_sel == old_sel, "R10 locked in cycle 12", mux_sel, old_sel);
    tick();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    chk(done_flag == 1'b1, "R6 set beats clear", done_flag, 1);
    chk(mux_sel == sel_a, "R11 release at completion", mux_sel, sel_a);
    chk(busy == 1'b1 && ext_active == 1'b0, "R8 second chain normal", {busy, ext_active}, 2);
    chk({res_hi[1:0], res_lo} == v2, "R5 free-run result 2", {res_hi[1:0], res_lo}, v2);
    vin = v3;
    sel_b = sel_a ^ 6'h2a;
    repeat (12) tick();
    sel_din = sel_b; sel_wr = 1'b1;
    tick();
    sel_wr = 1'b0;
    chk(mux_sel == sel_b, "R11 write in last cycle", mux_sel, sel_b);
    free_run = 1'b0;
    repeat (12) tick();
    chk(busy == 1'b1, "R8 final conversion running", busy, 1);
    tick();
    chk(busy == 1'b0 && start_bit == 1'b0, "R7 stop after free-run off", {busy, start_bit}, 0);
    chk({res_hi[1:0], res_lo} == v3, "R5 free-run result 4", {res_hi[1:0], res_lo}, v3);
    clear_flag();

    // R12: abort by disabling, then extended sequence again
    vin = 10'd300;
    start_wr = 1'b1;
    tick();
    start_wr = 1'b0;
    repeat (5) tick();
    en = 1'b0;
    tick();
    chk(busy == 1'b0 && start_bit == 1'b0, "R12 abort", {busy, start_bit}, 0);
    start_wr = 1'b1;
    tick();
    start_wr = 1'b0;
    chk(start_bit == 1'b0 && busy == 1'b0, "R12 start ignored while disabled", {busy, start_bit}, 0);
    repeat (20) tick();
    chk(done_flag == 1'b0, "R12 no flag", done_flag, 0);
    en = 1'b1;
    tick();
    run_conv(1'b1, 10'd77);
    clear_flag();
    run_conv(1'b0, 10'd512);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule